// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block sits beside the control logic of a byte-wide parallel flash array. It watches write cycles on the device bus and recognises the multi-step unlock sequences that software uses to start array operations. Recognised operations are byte program, whole-array erase, single-sector erase, boot-region lockout, entry into identification mode and exit from it. A single exit write is also accepted while identification mode is active.

A write counts only while the strobe, the chip enable and the output enable are all in their write levels. The strobe must also be held long enough to pass a glitch filter. When a write completes, the decoder advances its sequence state. On the last step of a sequence it emits a one-cycle command pulse with a command code and the captured target address and data. A busy input from the array timing logic blocks all commands and holds the decoder in its idle state. The array timing and the storage array are outside this block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While reset is active and after its release, `cmd_valid` is 0, `cmd_code` is 0 and `id_mode` is 0 until the first recognised command.
- R2: A write is taken only when `we_n`=0, `ce_n`=0 and `oe_n`=1 hold together for at least MIN_PULSE consecutive clock cycles (default 3). The write is recognised at the first clock edge at which the condition is gone. Shorter pulses have no effect on the sequence.
- R3: Every sequence opens with data 0xAA at an address whose bits 10..0 equal 0x555, then data 0x55 at an address whose bits 10..0 equal 0x2AA. Bits 16..11 of the address are ignored in these steps.
- R4: When the third write is 0xA0 at x555, the fourth write of any address and data gives a pulse with `cmd_code`=1. `cmd_addr` and `cmd_data` are that write's address and data. `cmd_valid` rises at the edge that recognises the write.
- R5: The third write 0x80 at x555, then 0xAA at x555, 0x55 at x2AA, and 0x10 at x555 as the sixth write, give `cmd_code`=2 (whole-array erase).
- R6: The same five-step prefix followed by 0x30 at any address gives `cmd_code`=3 (sector erase), with `cmd_addr` equal to the sixth write's full 17-bit address.
- R7: The same five-step prefix followed by 0x40 at x555 gives `cmd_code`=4 (boot-region lockout).
- R8: The third write 0x90 at x555 gives `cmd_code`=5 and sets `id_mode`. The third write 0xF0 at x555 gives `cmd_code`=6 and clears `id_mode`. `id_mode` changes only together with such a pulse.
- R9: In the idle state with `id_mode`=1, a single write of 0xF0 to any address gives `cmd_code`=6 and clears `id_mode`. With `id_mode`=0 the same write gives no pulse.
- R10: A write that does not match the next expected step returns the decoder to idle with no pulse. A continuation written after it is not completed.
- R11: While `busy`=1, no command pulse is produced and the sequence state returns to idle. A sequence partly written under busy is not resumed.
- R12: `cmd_valid` is high for exactly one cycle per recognised command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we_n | input | 1 | Write strobe, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low (a write needs it high) |
| addr | input | 17 | Bus address |
| din | input | 8 | Bus write data |
| busy | input | 1 | Array operation in progress; blocks commands |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_code | output | 3 | Command code (1 program, 2 array erase, 3 sector erase, 4 lockout, 5 ID entry, 6 ID exit) |
| cmd_addr | output | 17 | Address captured with the command |
| cmd_data | output | 8 | Data captured with the command |
| id_mode | output | 1 | Identification mode active |

## Verification
Each full sequence is driven with upper address bits set, so that bit 11 and the bits above it are shown to be ignored. The three six-step sequences share a prefix and differ only in their last write, which separates decoding on the final data value from decoding on the prefix. Near-miss patterns check that only complete, well-timed writes advance the state: a short strobe, a wrong third data value, and a sequence written under busy. Each is followed by what would have been a valid continuation. The single exit write is tried with identification mode both set and clear, to separate the mode-gated shortcut from the three-step exit.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int ADDR_W  = 17;
  localparam int DATA_W  = 8;
  localparam int MATCH_W = 11;

  localparam logic [MATCH_W-1:0] UNLOCK_A = 11'h555;
  localparam logic [MATCH_W-1:0] UNLOCK_B = 11'h2AA;

  typedef enum logic [2:0] {
    CMD_NONE     = 3'd0,
    CMD_PROGRAM  = 3'd1,
    CMD_ERASE_ALL= 3'd2,
    CMD_ERASE_SEC= 3'd3,
    CMD_BOOT_LOCK= 3'd4,
    CMD_ID_ENTER = 3'd5,
    CMD_ID_LEAVE = 3'd6
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_KEY1, ST_KEY2, ST_PROG, ST_EKEY0, ST_EKEY1, ST_EKEY2
  } seq_e;
endpackage

// File: rtl/flash_wr_filter.sv
module flash_wr_filter #(
  parameter int AW        = 17,
  parameter int DW        = 8,
  parameter int MIN_PULSE = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          wr_evt,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int CW = $clog2(MIN_PULSE + 1) + 1;
  localparam logic [CW-1:0] LIMIT = CW'(MIN_PULSE);

  logic          strobe;
  logic          strobe_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  assign strobe = ~we_n & ~ce_n & oe_n;

  always_comb begin
    if (!strobe)             cnt_d = '0;
    else if (cnt_q >= LIMIT) cnt_d = cnt_q;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      strobe_q <= strobe;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (strobe) begin
      addr_q <= addr;
      data_q <= din;
    end
  end

  assign wr_evt  = strobe_q & ~strobe & (cnt_q >= LIMIT);
  assign wr_addr = addr_q;
  assign wr_data = data_q;
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_evt,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          busy,
  output logic          cmd_valid,
  output logic [2:0]    cmd_code,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic          id_mode
);
  seq_e state_q, state_d;
  logic fire;
  cmd_e code_d;
  logic id_d;
  logic at_a, at_b;
  logic valid_q, id_q;
  cmd_e code_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  assign at_a = (wr_addr[MATCH_W-1:0] == UNLOCK_A);
  assign at_b = (wr_addr[MATCH_W-1:0] == UNLOCK_B);

  always_comb begin
    state_d = state_q;
    fire    = 1'b0;
    code_d  = CMD_NONE;
    id_d    = id_q;
    if (busy) begin
      state_d = ST_IDLE;
    end else if (wr_evt) begin
      state_d = ST_IDLE;
      unique case (state_q)
        ST_IDLE: begin
          if (at_a && wr_data == 8'hAA) state_d = ST_KEY1;
          else if (id_q && wr_data == 8'hF0) begin
            fire = 1'b1; code_d = CMD_ID_LEAVE; id_d = 1'b0;
          end
        end
        ST_KEY1:  if (at_b && wr_data == 8'h55) state_d = ST_KEY2;
        ST_KEY2: begin
          if (at_a) begin
            unique case (wr_data)
              8'hA0: state_d = ST_PROG;
              8'h80: state_d = ST_EKEY0;
              8'h90: begin fire = 1'b1; code_d = CMD_ID_ENTER; id_d = 1'b1; end
              8'hF0: begin fire = 1'b1; code_d = CMD_ID_LEAVE; id_d = 1'b0; end
              default: ;
            endcase
          end
        end
        ST_PROG: begin fire = 1'b1; code_d = CMD_PROGRAM; end
        ST_EKEY0: if (at_a && wr_data == 8'hAA) state_d = ST_EKEY1;
        ST_EKEY1: if (at_b && wr_data == 8'h55) state_d = ST_EKEY2;
        ST_EKEY2: begin
          if (wr_data == 8'h30) begin
            fire = 1'b1; code_d = CMD_ERASE_SEC;
          end else if (at_a && wr_data == 8'h10) begin
            fire = 1'b1; code_d = CMD_ERASE_ALL;
          end else if (at_a && wr_data == 8'h40) begin
            fire = 1'b1; code_d = CMD_BOOT_LOCK;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      valid_q <= 1'b0;
      id_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= fire;
      id_q    <= id_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CMD_NONE;
      addr_q <= '0;
      data_q <= '0;
    end else if (fire) begin
      code_q <= code_d;
      addr_q <= wr_addr;
      data_q <= wr_data;
    end
  end

  assign cmd_valid = valid_q;
  assign cmd_code  = code_q;
  assign cmd_addr  = addr_q;
  assign cmd_data  = data_q;
  assign id_mode   = id_q;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int MIN_PULSE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              busy,
  output logic              cmd_valid,
  output logic [2:0]        cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              id_mode
);
  logic              wr_evt;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  flash_wr_filter #(.AW(ADDR_W), .DW(DATA_W), .MIN_PULSE(MIN_PULSE)) u_filter (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .ce_n(ce_n), .oe_n(oe_n),
    .addr(addr), .din(din),
    .wr_evt(wr_evt), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  flash_seq_fsm #(.AW(ADDR_W), .DW(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .id_mode(id_mode)
  );
endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       wr_evt,
  input logic       cmd_valid,
  input logic [2:0] cmd_code,
  input logic       id_mode
);
  assert_pulse_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  assert_code_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_code != 3'd0);

  assert_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> $past(wr_evt));

  assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> !$past(busy));

  assert_entry_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'd5) |-> id_mode);

  assert_exit_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'd6) |-> !id_mode);

  assert_mode_with_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(id_mode) |-> cmd_valid);
endmodule

bind flash_cmd_decoder flash_cmd_checker u_checker (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wr_evt(wr_evt),
  .cmd_valid(cmd_valid), .cmd_code(cmd_code), .id_mode(id_mode)
);

// File: tb/flash_cmd_decoder_bench.sv
`timescale 1ns/1ps
module flash_cmd_decoder_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic we_n, ce_n, oe_n, busy;
  logic [16:0] addr;
  logic [7:0]  din;
  logic        cmd_valid, id_mode;
  logic [2:0]  cmd_code;
  logic [16:0] cmd_addr;
  logic [7:0]  cmd_data;

  int n_tests = 0;
  int n_fail  = 0;
  logic        g_v, g_after;
  logic [2:0]  g_c;
  logic [16:0] g_a;
  logic [7:0]  g_d;

  always #2.5 clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .ce_n(ce_n), .oe_n(oe_n),
    .addr(addr), .din(din), .busy(busy),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .id_mode(id_mode)
  );

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One bus write; samples the output after the recognising edge and the one after.
  task automatic wr(input logic [16:0] a, input logic [7:0] d, input int len = 3);
    @(negedge clk);
    addr = a; din = d; we_n = 1'b0; ce_n = 1'b0; oe_n = 1'b1;
    repeat (len) @(negedge clk);
    we_n = 1'b1; addr = 17'h0; din = 8'h0;
    @(negedge clk);
    g_v = cmd_valid; g_c = cmd_code; g_a = cmd_addr; g_d = cmd_data;
    @(negedge clk);
    g_after = cmd_valid;
  endtask

  task automatic expect_cmd(input string tag, input logic [2:0] c,
                            input logic [16:0] a, input logic [7:0] d);
    check(g_v == 1'b1, tag, "pulse", {31'b0, g_v}, 1);
    check(g_c == c, tag, "code", {29'b0, g_c}, {29'b0, c});
    check(g_a == a, tag, "addr", {15'b0, g_a}, {15'b0, a});
    check(g_d == d, tag, "data", {24'b0, g_d}, {24'b0, d});
    check(g_after == 1'b0, "R12", "pulse width", {31'b0, g_after}, 0);
  endtask

  task automatic expect_none(input string tag);
    check(g_v == 1'b0 && g_after == 1'b0, tag, "no pulse", {31'b0, g_v}, 0);
  endtask

  task automatic unlock(input logic [16:0] hi);
    wr(hi | 17'h00555, 8'hAA); expect_none("R3");
    wr(hi | 17'h00AAA, 8'h55); expect_none("R3");
  endtask

  task automatic t_reset();
    check(cmd_valid == 1'b0, "R1", "valid", {31'b0, cmd_valid}, 0);
    check(cmd_code == 3'd0, "R1", "code", {29'b0, cmd_code}, 0);
    check(id_mode == 1'b0, "R1", "id_mode", {31'b0, id_mode}, 0);
  endtask

  task automatic t_program();
    unlock(17'h1F000);
    wr(17'h10555, 8'hA0); expect_none("R4");
    wr(17'h0ABCD, 8'h3C); expect_cmd("R4", 3'd1, 17'h0ABCD, 8'h3C);
  endtask

  task automatic t_short_pulse();
    unlock(17'h0);
    wr(17'h00555, 8'hA0, 2); expect_none("R2");
    // the short write was dropped, so A0 now acts as the third step
    wr(17'h00555, 8'hA0); expect_none("R2");
    wr(17'h01234, 8'h5A); expect_cmd("R2", 3'd1, 17'h01234, 8'h5A);
  endtask

  task automatic erase_prefix(input logic [16:0] hi);
    unlock(hi);
    wr(hi | 17'h00555, 8'h80); expect_none("R5");
    wr(hi | 17'h00555, 8'hAA); expect_none("R5");
    wr(hi | 17'h002AA, 8'h55); expect_none("R5");
  endtask

  task automatic t_erase_family();
    erase_prefix(17'h0A000);
    wr(17'h18555, 8'h10); expect_cmd("R5", 3'd2, 17'h18555, 8'h10);
    erase_prefix(17'h00000);
    wr(17'h1A123, 8'h30); expect_cmd("R6", 3'd3, 17'h1A123, 8'h30);
    erase_prefix(17'h14800);
    wr(17'h00D55, 8'h40); expect_cmd("R7", 3'd4, 17'h00D55, 8'h40);
  endtask

  task automatic t_id_mode();
    unlock(17'h0);
    wr(17'h00555, 8'h90); expect_cmd("R8", 3'd5, 17'h00555, 8'h90);
    check(id_mode == 1'b1, "R8", "id_mode set", {31'b0, id_mode}, 1);
    unlock(17'h0);
    wr(17'h00555, 8'hF0); expect_cmd("R8", 3'd6, 17'h00555, 8'hF0);
    check(id_mode == 1'b0, "R8", "id_mode clear", {31'b0, id_mode}, 0);
    wr(17'h1C002, 8'hF0); expect_none("R9");
    unlock(17'h0);
    wr(17'h00555, 8'h90); expect_cmd("R8", 3'd5, 17'h00555, 8'h90);
    wr(17'h1C002, 8'hF0); expect_cmd("R9", 3'd6, 17'h1C002, 8'hF0);
    check(id_mode == 1'b0, "R9", "id_mode clear", {31'b0, id_mode}, 0);
  endtask

  task automatic t_mismatch();
    unlock(17'h0);
    wr(17'h00555, 8'h77); expect_none("R10");
    wr(17'h00555, 8'hA0); expect_none("R10");
    wr(17'h04444, 8'h11); expect_none("R10");
    unlock(17'h0);
    wr(17'h00556, 8'hA0); expect_none("R10");
    wr(17'h04444, 8'h11); expect_none("R10");
  endtask

  task automatic t_busy();
    busy = 1'b1;
    unlock(17'h0);
    wr(17'h00555, 8'hA0); expect_none("R11");
    wr(17'h02222, 8'h22); expect_none("R11");
    unlock(17'h0);
    busy = 1'b0;
    wr(17'h00555, 8'hA0); expect_none("R11");
    wr(17'h02222, 8'h22); expect_none("R11");
  endtask

  initial begin
    rst_n = 1'b0; we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b0; busy = 1'b0;
    addr = '0; din = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_program();
    t_short_pulse();
    t_erase_family();
    t_id_mode();
    t_mismatch();
    t_busy();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule